// File: doc/BRIEF.md
# Parallel Three-Tap FIR Filter

This block filters a stream of signed 24-bit samples with a three-tap finite impulse response. Each accepted sample is combined with the two samples accepted before it. Each of the three is weighted by its own coefficient, and the weighted terms are added into a signed 48-bit result. The user holds the three coefficient inputs steady. Each coefficient is read in the cycle a sample is accepted.

The three tap products are formed at the same time, each by its own radix-4 Booth multiplier. Each multiplier reduces its partial products with carry-save compressors and resolves them with a carry look-ahead adder. A single 3:2 compressor stage merges the three products into two vectors. A final 48-bit look-ahead adder turns those two vectors into the tap sum. The datapath has no behavioural multiply or add operator. The result is registered, and a flag marks the cycle that holds a fresh result.

Top module: `fir3_parallel`

## Requirements
- R1: A synchronous reset clears the two history registers, `out_result` and `out_valid` to zero. The first sample accepted after a reset therefore sees zero history.
- R2: Take a sample accepted in cycle n. In cycle n+1, `out_result` equals coef0·x[n] + coef1·x[n-1] + coef2·x[n-2]. Here x[n-1] and x[n-2] are the two samples accepted before x[n], and all values are signed two's complement.
- R3: The history advances only in cycles where `in_valid` is high. Idle cycles leave the previous samples unchanged, so the next result ignores how many idle cycles came before it.
- R4: `out_valid` is high in the cycle after a cycle with `in_valid` high. It is low in the cycle after a cycle with `in_valid` low.
- R5: `out_result` keeps its value through any cycle that follows a cycle with no accepted sample.
- R6: The 48-bit sum wraps modulo 2^48 when the true sum does not fit.
- R7: Each tap product is exact for all signed 24-bit operand pairs, including the most negative value on either side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the cycle in which `in_sample` is accepted |
| in_sample | input | 24 | New signed input sample |
| coef0 | input | 24 | Signed weight of the newest sample |
| coef1 | input | 24 | Signed weight of the sample one step older |
| coef2 | input | 24 | Signed weight of the sample two steps older |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_result | output | 48 | Registered signed filter output |

## Verification
The hardest case to reach is a sum that leaves the 48-bit range. This needs all three tap products large with the same sign at once, such as three most-negative samples against three most-negative coefficients. Uniform random operands almost never line up this way. The stimulus therefore mixes the extreme values 0, ±1, the largest positive and the most negative value into the random draws at a fixed rate. It also runs a directed sequence of three most-negative products, whose sum must wrap to -2^46. Random idle gaps between samples test that the history survives idle cycles.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    localparam int SAMPLE_W = 24;
    localparam int PROD_W   = 2 * SAMPLE_W;
    localparam int NTAP     = 3;
    localparam int NBOOTH   = SAMPLE_W / 2;
    localparam int NROW     = NBOOTH + 1;
    localparam int CLA_GRP  = 4;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [PROD_W-1:0]   wide_t;

    typedef struct packed {
        wide_t s;
        wide_t c;
    } cs_pair_t;

    typedef struct packed {
        sample_t d1;
        sample_t d2;
        wide_t   y;
        logic    v;
    } fir_state_t;

    // 3:2 compressor over a full word; the carry vector is pre-shifted
    function automatic cs_pair_t csa3(input wide_t a, input wide_t b, input wide_t c);
        cs_pair_t r;
        r.s = a ^ b ^ c;
        r.c = ((a & b) | (a & c) | (b & c)) << 1;
        return r;
    endfunction
endpackage

// File: rtl/fir3_cla.sv
module fir3_cla
    import fir3_pkg::*;
(
    input  wide_t a,
    input  wide_t b,
    output wide_t sum
);
    localparam int NGRP = PROD_W / CLA_GRP;

    always_comb begin
        wide_t            p;
        wide_t            g;
        logic [PROD_W-1:0] cy;
        logic [NGRP-1:0]  gg;
        logic [NGRP-1:0]  gp;
        logic [NGRP:0]    cg;
        p  = a ^ b;
        g  = a & b;
        cy = '0;
        for (int j = 0; j < NGRP; j++) begin
            gg[j] = 1'b0;
            gp[j] = 1'b1;
            for (int k = 0; k < CLA_GRP; k++) begin
                gg[j] = g[j*CLA_GRP+k] | (p[j*CLA_GRP+k] & gg[j]);
                gp[j] = gp[j] & p[j*CLA_GRP+k];
            end
        end
        cg[0] = 1'b0;
        for (int j = 0; j < NGRP; j++) begin
            cg[j+1] = gg[j] | (gp[j] & cg[j]);
        end
        for (int j = 0; j < NGRP; j++) begin
            cy[j*CLA_GRP] = cg[j];
            for (int k = 1; k < CLA_GRP; k++) begin
                cy[j*CLA_GRP+k] = g[j*CLA_GRP+k-1] | (p[j*CLA_GRP+k-1] & cy[j*CLA_GRP+k-1]);
            end
        end
        sum = p ^ cy;
    end
endmodule

// File: rtl/fir3_booth_mul.sv
module fir3_booth_mul
    import fir3_pkg::*;
(
    input  sample_t mcand,
    input  sample_t mplier,
    output wide_t   product
);
    wide_t    pp_rows [NROW];
    cs_pair_t acc_d;

    always_comb begin
        wide_t                b1;
        wide_t                b2;
        wide_t                mag;
        wide_t                corr;
        logic                 neg;
        logic [SAMPLE_W:0]    ext;
        logic [2:0]           trip;
        b1   = {{SAMPLE_W{mcand[SAMPLE_W-1]}}, mcand};
        b2   = b1 << 1;
        ext  = {mplier, 1'b0};
        corr = '0;
        for (int i = 0; i < NBOOTH; i++) begin
            trip = ext[2*i +: 3];
            neg  = 1'b0;
            unique case (trip)
                3'b001, 3'b010: mag = b1;
                3'b011:         mag = b2;
                3'b100: begin   mag = b2; neg = 1'b1; end
                3'b101, 3'b110: begin mag = b1; neg = 1'b1; end
                default:        mag = '0;
            endcase
            pp_rows[i] = neg ? ((~mag) << (2*i)) : (mag << (2*i));
            corr[2*i]  = neg;
        end
        pp_rows[NBOOTH] = corr;
    end

    always_comb begin
        acc_d.s = pp_rows[0];
        acc_d.c = pp_rows[1];
        for (int r = 2; r < NROW; r++) begin
            acc_d = csa3(acc_d.s, acc_d.c, pp_rows[r]);
        end
    end

    fir3_cla u_final (
        .a   (acc_d.s),
        .b   (acc_d.c),
        .sum (product)
    );
endmodule

// File: rtl/fir3_parallel.sv
module fir3_parallel
    import fir3_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SAMPLE_W-1:0] coef0,
    input  logic [SAMPLE_W-1:0] coef1,
    input  logic [SAMPLE_W-1:0] coef2,
    output logic                out_valid,
    output logic [PROD_W-1:0]   out_result
);
    fir_state_t state_d, state_q;
    sample_t    tap_x [NTAP];
    sample_t    tap_c [NTAP];
    wide_t      tap_p [NTAP];
    cs_pair_t   merge_d;
    wide_t      tap_sum_d;

    assign tap_x[0] = in_sample;
    assign tap_x[1] = state_q.d1;
    assign tap_x[2] = state_q.d2;
    assign tap_c[0] = coef0;
    assign tap_c[1] = coef1;
    assign tap_c[2] = coef2;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        fir3_booth_mul u_mul (
            .mcand   (tap_x[t]),
            .mplier  (tap_c[t]),
            .product (tap_p[t])
        );
    end

    assign merge_d = csa3(tap_p[0], tap_p[1], tap_p[2]);

    fir3_cla u_sum (
        .a   (merge_d.s),
        .b   (merge_d.c),
        .sum (tap_sum_d)
    );

    always_comb begin
        state_d   = state_q;
        state_d.v = 1'b0;
        if (in_valid) begin
            state_d.d1 = in_sample;
            state_d.d2 = state_q.d1;
            state_d.y  = tap_sum_d;
            state_d.v  = 1'b1;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign out_valid  = state_q.v;
    assign out_result = state_q.y;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && state_q.d1 == '0 && state_q.d2 == '0));
    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    shift_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (state_q.d1 == $past(in_sample) && state_q.d2 == $past(state_q.d1)));
    // R3
    history_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(state_q.d1) && $stable(state_q.d2)));
    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
endmodule

// File: tb/fir3_parallel_tb.sv
module fir3_parallel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic [23:0] coef0 = '0;
    logic [23:0] coef1 = '0;
    logic [23:0] coef2 = '0;
    logic        out_valid;
    logic [47:0] out_result;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [23:0] hist1 = '0;
    logic [23:0] hist2 = '0;
    logic [47:0] exp_y = '0;

    localparam logic [23:0] MIN_V = 24'h800000;
    localparam logic [23:0] MAX_V = 24'h7FFFFF;

    always #4 clk = ~clk;

    fir3_parallel u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef0      (coef0),
        .coef1      (coef1),
        .coef2      (coef2),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [47:0] ref_fir(input logic [23:0] x, input logic [23:0] h1,
                                            input logic [23:0] h2, input logic [23:0] c0,
                                            input logic [23:0] c1, input logic [23:0] c2);
        longint t;
        t = sx(c0) * sx(x) + sx(c1) * sx(h1) + sx(c2) * sx(h2);
        return t[47:0];
    endfunction

    function automatic logic [23:0] pick24();
        int sel;
        sel = int'($urandom_range(0, 9));
        case (sel)
            0: return MIN_V;
            1: return MAX_V;
            2: return 24'hFFFFFF;
            3: return 24'h000001;
            4: return 24'h000000;
            default: return 24'($urandom());
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist1 = '0;
        hist2 = '0;
        exp_y = '0;
        // R1: cleared output and flag
        check(out_valid == 1'b0, "R1", 48'(out_valid), 48'd0);
        check(out_result == '0, "R1", out_result, 48'd0);
    endtask

    // Called at a falling edge; drives, then checks at the next falling edge
    task automatic step(input bit vld, input logic [23:0] x, input logic [23:0] c0,
                        input logic [23:0] c1, input logic [23:0] c2, input string tag);
        in_valid  = vld;
        in_sample = x;
        coef0 = c0;
        coef1 = c1;
        coef2 = c2;
        if (vld) begin
            exp_y = ref_fir(x, hist1, hist2, c0, c1, c2);
            hist2 = hist1;
            hist1 = x;
        end
        @(negedge clk);
        // R4: flag follows the accept strobe by one cycle
        check(out_valid == vld, "R4", 48'(out_valid), 48'(vld));
        if (vld) check(out_result == exp_y, tag, out_result, exp_y);
        else     check(out_result == exp_y, "R5", out_result, exp_y);
    endtask

    initial begin
        #(200000 * 8);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();

        // R1/R2: impulse after reset exposes each weight in turn
        step(1'b1, 24'd1, 24'd5, -24'sd7, 24'd9, "R1");
        step(1'b1, 24'd0, 24'd5, -24'sd7, 24'd9, "R2");
        // R3: idle gap must not disturb history
        step(1'b0, 24'hABCDEF, 24'd5, -24'sd7, 24'd9, "R3");
        step(1'b0, 24'h123456, 24'd5, -24'sd7, 24'd9, "R3");
        step(1'b1, 24'd0, 24'd5, -24'sd7, 24'd9, "R3");
        step(1'b1, 24'd0, 24'd5, -24'sd7, 24'd9, "R2");

        // R7: extreme products, R6: three most-negative terms wrap to -2^46
        do_reset();
        step(1'b1, MIN_V, MIN_V, MIN_V, MIN_V, "R7");
        step(1'b1, MIN_V, MIN_V, MIN_V, MIN_V, "R7");
        step(1'b1, MIN_V, MIN_V, MIN_V, MIN_V, "R6");
        check(out_result == 48'hC00000000000, "R6", out_result, 48'hC00000000000);
        step(1'b1, MAX_V, MIN_V, MAX_V, MAX_V, "R7");
        step(1'b1, 24'hFFFFFF, MAX_V, 24'hFFFFFF, MIN_V, "R7");

        // R2: random mix with idle gaps and extreme values
        for (int i = 0; i < 1500; i++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(v, pick24(), pick24(), pick24(), pick24(), "R2");
        end

        // R1: reset in the middle of a stream restores zero history
        do_reset();
        step(1'b1, 24'd3, 24'd4, MAX_V, MIN_V, "R1");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule